// File: doc/BRIEF.md
# Multi-Granularity Page Address Translator

This block turns a 16-bit relative address into a 17-bit physical core address. Each address class has its own bank of page registers, and each bank has its own page size. The request carries a class code, which picks the bank, the modulo range, the index bits and the in-page offset. The selected page register supplies a frame number, and the physical address is that frame number followed by the offset.

Each page register holds a frame number and a lock bit. A locked page stops the access and raises a lock fault. A separate guard can lock one single 512-word unit inside the user address space. The supervisor class may not be used while the user-mode input is high; such an access raises a class fault. Pages in the user bank carry a use bit, which is set when a page is accessed with success. Software can then tell which pages are unchanged and need not be copied out.

A privileged port writes any page register and reads it back. A write sets the frame number and the lock bit, and clears the use bit. Responses come out one clock after the request.

Top module: `addr_xlate`

## Requirements
- R1: While reset is active, and at the first edge after it, every response output is 0. Every page register reads back frame 0, lock 0 and use 0.
- R2: Class code 0 is the user class. It uses the whole 16-bit address. Bits [15:12] pick one of 16 pages, and phys_addr_o = {frame[4:0], addr[11:0]}.
- R3: Class code 1 is the system class. It takes the address modulo 2048. Bits [10:9] pick one of 4 pages, and phys_addr_o = {frame[7:0], addr[8:0]}.
- R4: Class code 2 is the workspace class. It takes the address modulo 256. Bits [7:6] pick one of 4 pages, and phys_addr_o = {frame[10:0], addr[5:0]}.
- R5: Class code 3 is the supervisor class. When sup_alias_i is 0, it uses one register and phys_addr_o = {frame[7:0], addr[8:0]}. When sup_alias_i is 1, it behaves exactly like class code 1.
- R6: An access to a page whose lock bit is set gives lock_fault_o=1, mem_req_o=0 and phys_addr_o=0. The supervisor register has no lock bit: a written lock bit is ignored and always reads back as 0.
- R7: A class 3 access with user_mode_i high gives class_fault_o=1, mem_req_o=0 and lock_fault_o=0, whatever the lock state.
- R8: When guard_en_i is high, a class 0 access with addr[15:9] equal to guard_unit_i gives a lock fault.
- R9: A class 0 access that raises no fault sets the use bit of its page. The new value is visible on read-back after that edge. An access that faults sets no use bit. Banks 1 to 3 always read back use 0.
- R10: A write to a page register loads the frame number (the low bits that fit the bank) and the lock bit, and clears the use bit. cfg_bank_i selects the bank: 0 user, 1 system, 2 workspace, 3 supervisor. cfg_idx_i gives the page; smaller banks use only its low bits. An access in the same cycle as a write to the same page uses the contents from before the write, and the clear of the use bit takes priority over the set.
- R11: rsp_valid_o follows req_valid_i one cycle later. mem_req_o, both fault outputs and phys_addr_o are 0 unless a valid request produced them, and phys_addr_o is 0 whenever mem_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_class_i | input | 2 | Address class code (0 to 3) |
| req_addr_i | input | 16 | Relative address |
| user_mode_i | input | 1 | Request comes from a user program |
| sup_alias_i | input | 1 | Class 3 behaves like class 1 |
| guard_en_i | input | 1 | Enable the single-unit guard |
| guard_unit_i | input | 7 | Guarded 512-word unit in user space |
| cfg_we_i | input | 1 | Page register write strobe |
| cfg_bank_i | input | 2 | Bank for write and read-back |
| cfg_idx_i | input | 4 | Page for write and read-back |
| cfg_frame_i | input | 11 | Frame number to write |
| cfg_lock_i | input | 1 | Lock bit to write |
| cfg_frame_o | output | 11 | Read-back frame number, zero-extended |
| cfg_lock_o | output | 1 | Read-back lock bit |
| cfg_use_o | output | 1 | Read-back use bit |
| rsp_valid_o | output | 1 | Response valid |
| mem_req_o | output | 1 | Memory request issued |
| phys_addr_o | output | 17 | Physical address |
| lock_fault_o | output | 1 | Lock or guard fault |
| class_fault_o | output | 1 | Class not allowed in user mode |

## Verification
Responses to a request are due exactly one edge after the edge that samples it. The bench reference model computes each expected response at that same edge, using the register state from before the edge. It compares the outputs at the following falling edge. Read-back is combinational on the state after the last edge, so any change to a use bit or from a write is due on read-back in the cycle that directly follows the edge. The same-edge case, where a write and an access hit one page, is driven on purpose to check which update takes priority.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int unsigned REL_W   = 16;
  localparam int unsigned PHYS_W  = 17;
  localparam int unsigned U_PAGES = 16;
  localparam int unsigned S_PAGES = 4;
  localparam int unsigned W_PAGES = 4;
  localparam int unsigned P_PAGES = 1;
  localparam int unsigned U_OFF   = 12;
  localparam int unsigned S_OFF   = 9;
  localparam int unsigned W_OFF   = 6;
  localparam int unsigned P_OFF   = 9;
  localparam int unsigned G_OFF   = 9;

  localparam int unsigned U_IDX   = $clog2(U_PAGES);
  localparam int unsigned S_IDX   = $clog2(S_PAGES);
  localparam int unsigned W_IDX   = $clog2(W_PAGES);
  localparam int unsigned U_FRAME = PHYS_W - U_OFF;
  localparam int unsigned S_FRAME = PHYS_W - S_OFF;
  localparam int unsigned W_FRAME = PHYS_W - W_OFF;
  localparam int unsigned P_FRAME = PHYS_W - P_OFF;
  localparam int unsigned GUARD_W = REL_W - G_OFF;
  localparam int unsigned CFG_FW  = W_FRAME;

  typedef enum logic [1:0] {
    BK_USER = 2'd0,
    BK_SYS  = 2'd1,
    BK_WORK = 2'd2,
    BK_SUP  = 2'd3
  } bank_e;
endpackage

// File: rtl/ptx_bank.sv
module ptx_bank #(
  parameter int unsigned NPAGE   = 4,
  parameter int unsigned FRAME_W = 8,
  parameter bit          HAS_LOCK = 1'b1,
  parameter bit          HAS_USE  = 1'b0,
  localparam int unsigned IDX_W  = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   lk_idx_i,
  output logic [FRAME_W-1:0] lk_frame_o,
  output logic               lk_lock_o,
  input  logic               touch_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic               wr_lock_i,
  output logic [FRAME_W-1:0] rb_frame_o,
  output logic               rb_lock_o,
  output logic               rb_use_o
);
  logic [NPAGE-1:0][FRAME_W-1:0] frame_q;
  logic [NPAGE-1:0]              lock_q;
  logic [NPAGE-1:0]              use_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
    end else if (wr_en_i) begin
      for (int p = 0; p < int'(NPAGE); p++)
        if (cfg_idx_i == IDX_W'(p)) frame_q[p] <= wr_frame_i;
    end
  end

  generate
    if (HAS_LOCK) begin : g_lock
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lock_q <= '0;
        end else if (wr_en_i) begin
          for (int p = 0; p < int'(NPAGE); p++)
            if (cfg_idx_i == IDX_W'(p)) lock_q[p] <= wr_lock_i;
        end
      end
    end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = wr_lock_i;
      assign lock_q      = '0;
    end

    if (HAS_USE) begin : g_use
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          use_q <= '0;
        end else begin
          for (int p = 0; p < int'(NPAGE); p++) begin
            // explicit write clear beats access set
            if (wr_en_i && cfg_idx_i == IDX_W'(p))      use_q[p] <= 1'b0;
            else if (touch_i && lk_idx_i == IDX_W'(p))  use_q[p] <= 1'b1;
          end
        end
      end
    end else begin : g_nouse
      logic unused_touch;
      assign unused_touch = touch_i;
      assign use_q        = '0;
    end
  endgenerate

  always_comb begin
    lk_frame_o = '0;
    lk_lock_o  = 1'b0;
    rb_frame_o = '0;
    rb_lock_o  = 1'b0;
    rb_use_o   = 1'b0;
    for (int p = 0; p < int'(NPAGE); p++) begin
      if (lk_idx_i == IDX_W'(p)) begin
        lk_frame_o = frame_q[p];
        lk_lock_o  = lock_q[p];
      end
      if (cfg_idx_i == IDX_W'(p)) begin
        rb_frame_o = frame_q[p];
        rb_lock_o  = lock_q[p];
        rb_use_o   = use_q[p];
      end
    end
  end
endmodule

// File: rtl/ptx_decode.sv
module ptx_decode
  import ptx_pkg::*;
(
  input  logic [1:0]       class_i,
  input  logic             alias_i,
  input  logic [REL_W-1:0] addr_i,
  output bank_e            bank_o,
  output logic [U_IDX-1:0] idx_o
);
  always_comb begin
    bank_o = BK_USER;
    idx_o  = '0;
    unique case (class_i)
      2'd0: begin
        bank_o = BK_USER;
        idx_o  = addr_i[U_OFF +: U_IDX];
      end
      2'd1: begin
        bank_o = BK_SYS;
        idx_o  = U_IDX'(addr_i[S_OFF +: S_IDX]);
      end
      2'd2: begin
        bank_o = BK_WORK;
        idx_o  = U_IDX'(addr_i[W_OFF +: W_IDX]);
      end
      default: begin
        if (alias_i) begin
          bank_o = BK_SYS;
          idx_o  = U_IDX'(addr_i[S_OFF +: S_IDX]);
        end else begin
          bank_o = BK_SUP;
          idx_o  = '0;
        end
      end
    endcase
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import ptx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_class_i,
  input  logic [REL_W-1:0]    req_addr_i,
  input  logic                user_mode_i,
  input  logic                sup_alias_i,
  input  logic                guard_en_i,
  input  logic [GUARD_W-1:0]  guard_unit_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_bank_i,
  input  logic [U_IDX-1:0]    cfg_idx_i,
  input  logic [CFG_FW-1:0]   cfg_frame_i,
  input  logic                cfg_lock_i,
  output logic [CFG_FW-1:0]   cfg_frame_o,
  output logic                cfg_lock_o,
  output logic                cfg_use_o,
  output logic                rsp_valid_o,
  output logic                mem_req_o,
  output logic [PHYS_W-1:0]   phys_addr_o,
  output logic                lock_fault_o,
  output logic                class_fault_o
);
  bank_e            lk_bank;
  logic [U_IDX-1:0] lk_idx;

  ptx_decode u_dec (
    .class_i (req_class_i),
    .alias_i (sup_alias_i),
    .addr_i  (req_addr_i),
    .bank_o  (lk_bank),
    .idx_o   (lk_idx)
  );

  logic [U_FRAME-1:0] u_frame, u_rb_frame;
  logic [S_FRAME-1:0] s_frame, s_rb_frame;
  logic [W_FRAME-1:0] w_frame, w_rb_frame;
  logic [P_FRAME-1:0] p_frame, p_rb_frame;
  logic u_lock, s_lock, w_lock, p_lock;
  logic u_rb_lock, s_rb_lock, w_rb_lock, p_rb_lock;
  logic u_rb_use, s_rb_use, w_rb_use, p_rb_use;
  logic touch_u, go;

  ptx_bank #(.NPAGE(U_PAGES), .FRAME_W(U_FRAME), .HAS_LOCK(1'b1), .HAS_USE(1'b1)) u_bank_user (
    .clk_i, .rst_ni,
    .lk_idx_i (lk_idx), .lk_frame_o (u_frame), .lk_lock_o (u_lock),
    .touch_i  (touch_u),
    .wr_en_i  (cfg_we_i && cfg_bank_i == 2'(BK_USER)),
    .cfg_idx_i (cfg_idx_i), .wr_frame_i (cfg_frame_i[U_FRAME-1:0]), .wr_lock_i (cfg_lock_i),
    .rb_frame_o (u_rb_frame), .rb_lock_o (u_rb_lock), .rb_use_o (u_rb_use)
  );

  ptx_bank #(.NPAGE(S_PAGES), .FRAME_W(S_FRAME), .HAS_LOCK(1'b1), .HAS_USE(1'b0)) u_bank_sys (
    .clk_i, .rst_ni,
    .lk_idx_i (lk_idx[S_IDX-1:0]), .lk_frame_o (s_frame), .lk_lock_o (s_lock),
    .touch_i  (1'b0),
    .wr_en_i  (cfg_we_i && cfg_bank_i == 2'(BK_SYS)),
    .cfg_idx_i (cfg_idx_i[S_IDX-1:0]), .wr_frame_i (cfg_frame_i[S_FRAME-1:0]), .wr_lock_i (cfg_lock_i),
    .rb_frame_o (s_rb_frame), .rb_lock_o (s_rb_lock), .rb_use_o (s_rb_use)
  );

  ptx_bank #(.NPAGE(W_PAGES), .FRAME_W(W_FRAME), .HAS_LOCK(1'b1), .HAS_USE(1'b0)) u_bank_work (
    .clk_i, .rst_ni,
    .lk_idx_i (lk_idx[W_IDX-1:0]), .lk_frame_o (w_frame), .lk_lock_o (w_lock),
    .touch_i  (1'b0),
    .wr_en_i  (cfg_we_i && cfg_bank_i == 2'(BK_WORK)),
    .cfg_idx_i (cfg_idx_i[W_IDX-1:0]), .wr_frame_i (cfg_frame_i[W_FRAME-1:0]), .wr_lock_i (cfg_lock_i),
    .rb_frame_o (w_rb_frame), .rb_lock_o (w_rb_lock), .rb_use_o (w_rb_use)
  );

  ptx_bank #(.NPAGE(P_PAGES), .FRAME_W(P_FRAME), .HAS_LOCK(1'b0), .HAS_USE(1'b0)) u_bank_sup (
    .clk_i, .rst_ni,
    .lk_idx_i (1'b0), .lk_frame_o (p_frame), .lk_lock_o (p_lock),
    .touch_i  (1'b0),
    .wr_en_i  (cfg_we_i && cfg_bank_i == 2'(BK_SUP)),
    .cfg_idx_i (1'b0), .wr_frame_i (cfg_frame_i[P_FRAME-1:0]), .wr_lock_i (cfg_lock_i),
    .rb_frame_o (p_rb_frame), .rb_lock_o (p_rb_lock), .rb_use_o (p_rb_use)
  );

  logic              cls_fault, guard_hit, sel_lock, lock_hit;
  logic [PHYS_W-1:0] phys_c;

  assign cls_fault = req_valid_i && req_class_i == 2'd3 && user_mode_i;
  assign guard_hit = guard_en_i && lk_bank == BK_USER &&
                     req_addr_i[REL_W-1:G_OFF] == guard_unit_i;

  always_comb begin
    unique case (lk_bank)
      BK_USER: begin sel_lock = u_lock; phys_c = {u_frame, req_addr_i[U_OFF-1:0]}; end
      BK_SYS:  begin sel_lock = s_lock; phys_c = {s_frame, req_addr_i[S_OFF-1:0]}; end
      BK_WORK: begin sel_lock = w_lock; phys_c = {w_frame, req_addr_i[W_OFF-1:0]}; end
      default: begin sel_lock = p_lock; phys_c = {p_frame, req_addr_i[P_OFF-1:0]}; end
    endcase
  end

  assign lock_hit = sel_lock || guard_hit;
  assign go       = req_valid_i && !cls_fault && !lock_hit;
  assign touch_u  = go && lk_bank == BK_USER;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      mem_req_o     <= 1'b0;
      lock_fault_o  <= 1'b0;
      class_fault_o <= 1'b0;
      phys_addr_o   <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      mem_req_o     <= go;
      lock_fault_o  <= req_valid_i && !cls_fault && lock_hit;
      class_fault_o <= cls_fault;
      phys_addr_o   <= go ? phys_c : '0;
    end
  end

  always_comb begin
    unique case (cfg_bank_i)
      2'(BK_USER): begin cfg_frame_o = CFG_FW'(u_rb_frame); cfg_lock_o = u_rb_lock; cfg_use_o = u_rb_use; end
      2'(BK_SYS):  begin cfg_frame_o = CFG_FW'(s_rb_frame); cfg_lock_o = s_rb_lock; cfg_use_o = s_rb_use; end
      2'(BK_WORK): begin cfg_frame_o = CFG_FW'(w_rb_frame); cfg_lock_o = w_rb_lock; cfg_use_o = w_rb_use; end
      default:     begin cfg_frame_o = CFG_FW'(p_rb_frame); cfg_lock_o = p_rb_lock; cfg_use_o = p_rb_use; end
    endcase
  end
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk
  import ptx_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [1:0]          req_class_i,
  input logic [REL_W-1:0]    req_addr_i,
  input logic                user_mode_i,
  input logic                sup_alias_i,
  input logic                guard_en_i,
  input logic [GUARD_W-1:0]  guard_unit_i,
  input logic                cfg_we_i,
  input logic [1:0]          cfg_bank_i,
  input logic [U_IDX-1:0]    cfg_idx_i,
  input logic [CFG_FW-1:0]   cfg_frame_i,
  input logic                cfg_lock_i,
  input logic [CFG_FW-1:0]   cfg_frame_o,
  input logic                cfg_lock_o,
  input logic                cfg_use_o,
  input logic                rsp_valid_o,
  input logic                mem_req_o,
  input logic [PHYS_W-1:0]   phys_addr_o,
  input logic                lock_fault_o,
  input logic                class_fault_o
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !mem_req_o && !lock_fault_o && !class_fault_o);

  // R11
  zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> phys_addr_o == '0);

  // R7
  class_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_class_i == 2'd3 && user_mode_i |=> class_fault_o && !mem_req_o && !lock_fault_o);

  // R8
  guard_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_class_i == 2'd0 && guard_en_i && req_addr_i[REL_W-1:G_OFF] == guard_unit_i
    |=> lock_fault_o && !mem_req_o);

  // R6
  sup_nolock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bank_i == 2'd3 |-> !cfg_lock_o);

  // R6
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, lock_fault_o, class_fault_o}));

  // R9
  no_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bank_i != 2'd0 |-> !cfg_use_o);

  // R10
  write_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_bank_i != 2'd3 |=>
      ((cfg_bank_i == $past(cfg_bank_i) && cfg_idx_i == $past(cfg_idx_i)) ->
       (cfg_lock_o == $past(cfg_lock_i) && !cfg_use_o)));
endmodule

bind addr_xlate addr_xlate_chk u_chk (.*);

// File: tb/addr_xlate_tb.sv
`timescale 1ns/1ps
module addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic [15:0] req_addr = '0;
  logic        user_mode = 1'b0, sup_alias = 1'b0, guard_en = 1'b0;
  logic [6:0]  guard_unit = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [3:0]  cfg_idx = '0;
  logic [10:0] cfg_frame = '0;
  logic        cfg_lock = 1'b0;
  logic [10:0] rb_frame;
  logic        rb_lock, rb_use, rsp_valid, mem_req, lock_fault, class_fault;
  logic [16:0] phys_addr;

  addr_xlate u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_class_i (req_class), .req_addr_i (req_addr),
    .user_mode_i (user_mode), .sup_alias_i (sup_alias),
    .guard_en_i (guard_en), .guard_unit_i (guard_unit),
    .cfg_we_i (cfg_we), .cfg_bank_i (cfg_bank), .cfg_idx_i (cfg_idx),
    .cfg_frame_i (cfg_frame), .cfg_lock_i (cfg_lock),
    .cfg_frame_o (rb_frame), .cfg_lock_o (rb_lock), .cfg_use_o (rb_use),
    .rsp_valid_o (rsp_valid), .mem_req_o (mem_req), .phys_addr_o (phys_addr),
    .lock_fault_o (lock_fault), .class_fault_o (class_fault)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int  m_frame[4][16];
  bit  m_lock[4][16];
  bit  m_use[4][16];
  bit  e_rv, e_mem, e_lf, e_cf;
  int  e_phys;
  string e_tag = "R1";

  function automatic int bidx(int b, int i);
    if (b == 0) return i & 15;
    if (b == 3) return 0;
    return i & 3;
  endfunction

  function automatic int fmask(int b);
    case (b)
      0: return 'h1f;
      2: return 'h7ff;
      default: return 'hff;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int b, i, off, sh, a, wb, wi;
    bit cf, gh, lk;
    if (!rst_n) begin
      foreach (m_frame[x, y]) begin m_frame[x][y] = 0; m_lock[x][y] = 0; m_use[x][y] = 0; end
      e_rv = 0; e_mem = 0; e_lf = 0; e_cf = 0; e_phys = 0; e_tag = "R1";
    end else begin
      a = int'(req_addr);
      case (req_class)
        2'd0: begin b = 0; i = a >> 12; off = a & 'hfff; sh = 12; end
        2'd1: begin b = 1; i = (a >> 9) & 3; off = a & 511; sh = 9; end
        2'd2: begin b = 2; i = (a >> 6) & 3; off = a & 63; sh = 6; end
        default: begin
          if (sup_alias) begin b = 1; i = (a >> 9) & 3; end
          else begin b = 3; i = 0; end
          off = a & 511; sh = 9;
        end
      endcase
      cf = req_valid && req_class == 2'd3 && user_mode;
      gh = (b == 0) && guard_en && (((a >> 9) & 127) == int'(guard_unit));
      lk = m_lock[b][i] || gh;
      e_rv = req_valid;
      e_cf = cf;
      e_lf = req_valid && !cf && lk;
      e_mem = req_valid && !cf && !lk;
      e_phys = e_mem ? ((m_frame[b][i] << sh) | off) : 0;
      if (!req_valid) e_tag = "R11";
      else if (cf) e_tag = "R7";
      else if (gh) e_tag = "R8";
      else if (lk) e_tag = "R6";
      else if (req_class == 2'd3) e_tag = "R5";
      else if (b == 0) e_tag = "R2";
      else if (b == 1) e_tag = "R3";
      else e_tag = "R4";
      if (e_mem && b == 0) m_use[0][i] = 1;
      if (cfg_we) begin
        wb = int'(cfg_bank);
        wi = bidx(wb, int'(cfg_idx));
        m_frame[wb][wi] = int'(cfg_frame) & fmask(wb);
        m_lock[wb][wi]  = (wb == 3) ? 1'b0 : cfg_lock;
        m_use[wb][wi]   = 1'b0;
      end
    end
  end

  task automatic compare();
    int b, i;
    b = int'(cfg_bank);
    i = bidx(b, int'(cfg_idx));
    chk(e_tag, int'(phys_addr), e_phys);
    chk(rst_n ? "R11" : "R1", int'(rsp_valid), int'(e_rv));
    chk(e_tag, int'(mem_req), int'(e_mem));
    chk(e_tag, int'(lock_fault), int'(e_lf));
    chk(rst_n ? "R7" : "R1", int'(class_fault), int'(e_cf));
    chk(rst_n ? "R10" : "R1", int'(rb_frame), m_frame[b][i]);
    chk(rst_n ? ((b == 3) ? "R6" : "R10") : "R1", int'(rb_lock), int'(m_lock[b][i]));
    chk(rst_n ? "R9" : "R1", int'(rb_use), int'(m_use[b][i]));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic acc(int cls, int addr);
    req_valid = 1'b1; req_class = 2'(cls); req_addr = 16'(addr);
    step();
    req_valid = 1'b0;
  endtask

  task automatic wr(int b, int i, int f, bit l);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_idx = 4'(i); cfg_frame = 11'(f); cfg_lock = l;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic view(int b, int i);
    cfg_bank = 2'(b); cfg_idx = 4'(i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state, sweep read-back
    for (int k = 0; k < 8; k++) begin
      view(k & 3, k * 5);
      step();
    end
    rst_n = 1'b1;
    view(0, 0);
    step();

    // R10: program every page
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < ((b == 0) ? 16 : (b == 3) ? 1 : 4); i++)
        wr(b, i, b * 37 + i * 11 + 5 + ((b == 2) ? 'h400 : 0), 1'b0);

    // R2
    for (int i = 0; i < 16; i++) acc(0, (i << 12) | ((i * 97) & 'hfff));
    // R3: modulo 2048
    for (int k = 0; k < 6; k++) acc(1, 'hf800 | (k * 300));
    // R4: modulo 256
    for (int k = 0; k < 6; k++) acc(2, 'hab00 | (k * 45));
    // R5: single register, then alias to system bank
    sup_alias = 1'b0; acc(3, 'hffff); acc(3, 'h1234);
    sup_alias = 1'b1; acc(3, 'h0a55); acc(3, 'hfe01);
    sup_alias = 1'b0;

    // R6: locked pages in each lockable bank; supervisor lock ignored
    wr(0, 3, 9, 1'b1); acc(0, 'h3123);
    wr(1, 2, 77, 1'b1); acc(1, 'h0421);
    wr(2, 1, 'h3ff, 1'b1); acc(2, 'h0047);
    wr(3, 0, 'h5a, 1'b1); view(3, 0); acc(3, 'h0101); step();

    // R7: supervisor class from user mode, both configurations
    user_mode = 1'b1;
    acc(3, 'h0010); sup_alias = 1'b1; acc(3, 'h0410); sup_alias = 1'b0;
    acc(0, 'h1000);
    user_mode = 1'b0;

    // R8: guarded unit 0x15 (0x2a00..0x2bff)
    guard_en = 1'b1; guard_unit = 7'h15;
    acc(0, 'h2a07); acc(0, 'h2bff); acc(0, 'h2c00); acc(0, 'h29ff);
    guard_en = 1'b0; acc(0, 'h2a07);

    // R9: use bit set on success, not on fault
    wr(0, 5, 4, 1'b0); view(0, 5); step();
    acc(0, 'h5000); step();
    wr(0, 6, 6, 1'b1); view(0, 6); acc(0, 'h6000); step();
    view(1, 0); acc(1, 'h0000); step();

    // R10: write and access to the same page in one cycle
    view(0, 7); acc(0, 'h7001); step();
    cfg_we = 1'b1; cfg_bank = 2'd0; cfg_idx = 4'd7; cfg_frame = 11'h1e; cfg_lock = 1'b1;
    req_valid = 1'b1; req_class = 2'd0; req_addr = 16'h7002;
    step();
    cfg_we = 1'b0;
    acc(0, 'h7003); step();

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      req_valid = ($urandom % 4) != 0;
      req_class = 2'($urandom);
      req_addr  = 16'($urandom);
      user_mode = ($urandom % 4) == 0;
      sup_alias = ($urandom % 2) == 0;
      guard_en  = ($urandom % 3) == 0;
      guard_unit = ($urandom % 2) ? req_addr[15:9] : 7'($urandom);
      cfg_we    = ($urandom % 8) == 0;
      cfg_bank  = 2'($urandom);
      cfg_idx   = 4'($urandom);
      cfg_frame = 11'($urandom);
      cfg_lock  = ($urandom % 3) == 0;
      step();
    end
    req_valid = 1'b0; cfg_we = 1'b0;
    step(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule